// File: doc/BRIEF.md
# Goldschmidt Divide and Square-Root Significand Unit

This block computes either the quotient a/b or the square root of a for two normalized significands in [1,2). It works by Goldschmidt iteration. A small table supplies a reciprocal seed (for divide) or a reciprocal-square-root seed (for square root). A single combinational multiplier is reused on every cycle. One value, the denominator track, is driven towards 1 while the other track converges on the answer. Both tracks are multiplied by a common factor. For divide that factor is two minus the denominator track. For square root it is three minus that track, halved, and the denominator track takes the factor twice per pass.

After a fixed number of passes, a correction cycle uses the same multiplier to square the candidate result, or multiply it by the divisor. It then moves the candidate by one unit in the last place where needed, so that the result is exactly the truncated value. A caller presents operands with a one-cycle start strobe and reads the result when the done pulse appears. Exponent, sign and special-value handling belong to the surrounding floating-point logic.

Top module: `gold_divsqrt`

## Requirements
- R1: With op_sqrt_i = 0, the result equals floor(A·2^(W-1)/B). A and B are the W-bit operand codes, with bit W-1 set and weight 2^-(W-1) per code step.
- R2: With op_sqrt_i = 1, the result equals floor(sqrt(A·2^(W-1))), which is the truncated square root of a in the same W-bit format.
- R3: A divide accepted at a rising edge raises done_o after the rising edge 4+2·ITERS edges later. done_o stays high for exactly one cycle.
- R4: A square root accepted at a rising edge raises done_o after the rising edge 4+3·ITERS edges later. done_o stays high for exactly one cycle.
- R5: A start_i seen while an operation is in flight is ignored. The running operation keeps its result and its timing, and no extra done pulse appears.
- R6: After reset, result_o is zero and done_o is low.
- R7: result_o changes only together with a done pulse. Operand or mode changes without an accepted start leave it unchanged.
- R8: op_sqrt_i selects the function (0 = divide, 1 = square root). In square-root mode the value on b_i has no effect on the result.
- R9: Equal operands give exactly 1.0 (code 2^(W-1)). The largest dividend over the smallest divisor gives the largest code, and the smallest dividend over the largest divisor gives floor(2^(2W-2)/(2^W-1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_sqrt_i | input | 1 | 0 selects divide, 1 selects square root |
| a_i | input | W | Dividend or radicand significand, Q1.(W-1) |
| b_i | input | W | Divisor significand, Q1.(W-1) |
| result_o | output | W | Truncated result significand, Q1.(W-1) |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench builds the unit with W = 7, SEED_BITS = 4, ITERS = 3 and GUARD = 6. At these values every one of the 4096 dividend/divisor pairs and all 64 radicands can be run and compared against integer long division and integer square root. The 16-entry seed tables leave a large initial error, so the three passes and the final one-step correction are both exercised hard. The short latency also leaves room to probe start strobes during busy cycles and to check that the held result survives operand changes.

// File: rtl/gold_divsqrt_pkg.sv
package gold_divsqrt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEED = 3'd1,
        ST_PRE0 = 3'd2,
        ST_PRE1 = 3'd3,
        ST_ITER = 3'd4,
        ST_CORR = 3'd5
    } gs_state_e;

endpackage

// File: rtl/gold_mul.sv
module gold_mul #(
    parameter int XW = 31
) (
    input  logic [XW-1:0]   op_a_i,
    input  logic [XW-1:0]   op_b_i,
    output logic [2*XW-1:0] prod_o
);

    assign prod_o = (2*XW)'(op_a_i) * (2*XW)'(op_b_i);

endmodule

// File: rtl/gold_factor.sv
module gold_factor #(
    parameter int F  = 29,
    parameter int XW = 31
) (
    input  logic [XW-1:0] d_i,
    input  logic          sqrt_i,
    output logic [XW-1:0] r_o
);

    localparam logic [XW:0] TWO_C   = (XW+1)'(2) << F;
    localparam logic [XW:0] THREE_C = (XW+1)'(3) << F;

    logic [XW:0] diff;

    // divide: 2 - d ; square root: (3 - d) / 2
    assign diff = sqrt_i ? (THREE_C - {1'b0, d_i}) : (TWO_C - {1'b0, d_i});
    assign r_o  = sqrt_i ? diff[XW:1] : diff[XW-1:0];

endmodule

// File: rtl/gold_seed_rom.sv
module gold_seed_rom #(
    parameter int SEED_BITS = 8,
    parameter int F         = 29,
    parameter int XW        = 31
) (
    input  logic [SEED_BITS-1:0] idx_i,
    input  logic                 sqrt_i,
    output logic [XW-1:0]        seed_o
);

    localparam int ENTRIES = 1 << SEED_BITS;
    localparam int PREC    = SEED_BITS + 4;

    function automatic logic [63:0] isqrt64(input logic [63:0] v);
        logic [63:0] root;
        logic [63:0] trial;
        root = '0;
        for (int i = 31; i >= 0; i--) begin
            trial = root | (64'd1 << i);
            if (trial * trial <= v) root = trial;
        end
        return root;
    endfunction

    function automatic logic [XW-1:0] scale_prec(input logic [63:0] v);
        if (F >= PREC) return XW'(v << (F - PREC));
        else           return XW'(v >> (PREC - F));
    endfunction

    function automatic logic [XW-1:0] recip_entry(input int k);
        logic [63:0] den;
        logic [63:0] num;
        den = (64'd1 << (SEED_BITS + 1)) + 64'(2 * k + 1);
        num = 64'd1 << (PREC + SEED_BITS + 1);
        return scale_prec(num / den);
    endfunction

    function automatic logic [XW-1:0] rsqrt_entry(input int k);
        logic [63:0] den;
        logic [63:0] num;
        den = (64'd1 << (SEED_BITS + 1)) + 64'(2 * k + 1);
        num = 64'd1 << (2 * PREC + SEED_BITS + 1);
        return scale_prec(isqrt64(num / den));
    endfunction

    logic [XW-1:0] rec_tab [ENTRIES];
    logic [XW-1:0] rsq_tab [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        localparam logic [XW-1:0] REC_V = recip_entry(k);
        localparam logic [XW-1:0] RSQ_V = rsqrt_entry(k);
        assign rec_tab[k] = REC_V;
        assign rsq_tab[k] = RSQ_V;
    end

    assign seed_o = sqrt_i ? rsq_tab[idx_i] : rec_tab[idx_i];

endmodule

// File: rtl/gold_divsqrt.sv
module gold_divsqrt
    import gold_divsqrt_pkg::*;
#(
    parameter int W         = 24,
    parameter int SEED_BITS = 8,
    parameter int ITERS     = 3,
    parameter int GUARD     = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         op_sqrt_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    localparam int F   = W - 1 + GUARD;   // internal fraction bits
    localparam int XW  = F + 2;           // two integer bits
    localparam int PW  = 2 * XW;
    localparam int ITW = $clog2(ITERS + 1);

    typedef struct packed {
        gs_state_e     st;
        logic          sqrt;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [XW-1:0] seed;
        logic [XW-1:0] n;      // converges to the result
        logic [XW-1:0] d;      // converges to one
        logic [XW-1:0] r;      // factor of the current pass
        logic [1:0]    step;
        logic [ITW-1:0] iter;
        logic [W-1:0]  res;
        logic          done;
    } regs_t;

    regs_t s_q, s_d;

    logic [XW-1:0]        mul_a, mul_b;
    logic [PW-1:0]        prod;
    logic [XW-1:0]        prod_mid;
    logic [XW-1:0]        seed_w;
    logic [XW-1:0]        r_now;
    logic [XW-1:0]        a_ext, b_ext;
    logic [XW-1:0]        q_cand;
    logic [W-1:0]         q_adj;
    logic [PW-1:0]        target;
    logic [PW-1:0]        incr;
    logic [SEED_BITS-1:0] seed_idx;
    logic                 last_step;

    assign a_ext    = {1'b0, s_q.a, {GUARD{1'b0}}};
    assign b_ext    = {1'b0, s_q.b, {GUARD{1'b0}}};
    assign q_cand   = s_q.n >> GUARD;
    assign target   = PW'({s_q.a, {(W-1){1'b0}}});
    assign incr     = s_q.sqrt ? PW'({q_cand, 1'b1}) : PW'(s_q.b);
    assign prod_mid = prod[F +: XW];
    assign seed_idx = s_q.sqrt ? s_q.a[W-2 -: SEED_BITS] : s_q.b[W-2 -: SEED_BITS];

    gold_mul #(.XW(XW)) u_mul (
        .op_a_i (mul_a),
        .op_b_i (mul_b),
        .prod_o (prod)
    );

    gold_factor #(.F(F), .XW(XW)) u_factor (
        .d_i    (s_q.d),
        .sqrt_i (s_q.sqrt),
        .r_o    (r_now)
    );

    gold_seed_rom #(.SEED_BITS(SEED_BITS), .F(F), .XW(XW)) u_seed (
        .idx_i  (seed_idx),
        .sqrt_i (s_q.sqrt),
        .seed_o (seed_w)
    );

    // one-step correction of the truncated candidate
    always_comb begin
        if (prod > target) begin
            q_adj = q_cand[W-1:0] - 1'b1;
        end else if (prod + incr <= target) begin
            q_adj = q_cand[W-1:0] + 1'b1;
        end else begin
            q_adj = q_cand[W-1:0];
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mul_a     = '0;
        mul_b     = '0;
        last_step = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_SEED;
                    s_d.sqrt = op_sqrt_i;
                    s_d.a    = a_i;
                    s_d.b    = b_i;
                end
            end
            ST_SEED: begin
                s_d.seed = seed_w;
                s_d.st   = ST_PRE0;
            end
            ST_PRE0: begin
                mul_a  = a_ext;
                mul_b  = s_q.seed;
                s_d.n  = prod_mid;
                s_d.st = ST_PRE1;
            end
            ST_PRE1: begin
                // square root: d = a*s*s, built from the scaled n
                mul_a    = s_q.sqrt ? s_q.n : b_ext;
                mul_b    = s_q.seed;
                s_d.d    = prod_mid;
                s_d.step = 2'd0;
                s_d.iter = '0;
                s_d.st   = ST_ITER;
            end
            ST_ITER: begin
                case (s_q.step)
                    2'd0: begin
                        mul_a    = s_q.n;
                        mul_b    = r_now;
                        s_d.n    = prod_mid;
                        s_d.r    = r_now;
                        s_d.step = 2'd1;
                    end
                    2'd1: begin
                        mul_a = s_q.d;
                        mul_b = s_q.r;
                        s_d.d = prod_mid;
                        if (s_q.sqrt) s_d.step = 2'd2;
                        else          last_step = 1'b1;
                    end
                    default: begin
                        mul_a     = s_q.d;
                        mul_b     = s_q.r;
                        s_d.d     = prod_mid;
                        last_step = 1'b1;
                    end
                endcase
                if (last_step) begin
                    s_d.step = 2'd0;
                    if (s_q.iter == ITW'(ITERS - 1)) s_d.st = ST_CORR;
                    else                             s_d.iter = s_q.iter + 1'b1;
                end
            end
            ST_CORR: begin
                mul_a    = q_cand;
                mul_b    = s_q.sqrt ? q_cand : XW'(s_q.b);
                s_d.res  = q_adj;
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign result_o = s_q.res;
    assign done_o   = s_q.done;

endmodule

// File: rtl/gold_divsqrt_chk.sv
module gold_divsqrt_chk #(
    parameter int W     = 24,
    parameter int ITERS = 3
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         start_i,
    input logic         op_sqrt_i,
    input logic         done_o,
    input logic [W-1:0] result_o
);

    localparam int LAT_DIV  = 5 + 2 * ITERS;
    localparam int LAT_SQRT = 5 + 3 * ITERS;
    localparam int CW       = $clog2(LAT_SQRT + 1);

    logic [CW-1:0] cnt_q;
    logic          mode_q;
    logic [CW-1:0] lat_end;

    assign lat_end = mode_q ? CW'(LAT_SQRT) : CW'(LAT_DIV);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (cnt_q == '0 || cnt_q == lat_end) begin
            if (start_i) begin
                cnt_q  <= CW'(1);
                mode_q <= op_sqrt_i;
            end else begin
                cnt_q  <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_div_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !mode_q) |-> (cnt_q == CW'(LAT_DIV)));

    assert_sqrt_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && mode_q) |-> (cnt_q == CW'(LAT_SQRT)));

    assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_due_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && cnt_q == lat_end) |-> done_o);

    assert_no_stray_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cnt_q != '0));

    assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

endmodule

bind gold_divsqrt gold_divsqrt_chk #(.W(W), .ITERS(ITERS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_sqrt_i (op_sqrt_i),
    .done_o    (done_o),
    .result_o  (result_o)
);

// File: tb/gold_divsqrt_tb.sv
`timescale 1ns/1ps
module gold_divsqrt_tb;

    localparam int W     = 7;
    localparam int SB    = 4;
    localparam int IT    = 3;
    localparam int GD    = 6;
    localparam int NDIV  = 5 + 2 * IT;   // negedges from drive to done
    localparam int NSQRT = 5 + 3 * IT;
    localparam int AMIN  = 1 << (W - 1);
    localparam int AMAX  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] res;
    logic         done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gold_divsqrt #(.W(W), .SEED_BITS(SB), .ITERS(IT), .GUARD(GD)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .op_sqrt_i (op),
        .a_i       (a),
        .b_i       (b),
        .result_o  (res),
        .done_o    (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    function automatic int exp_div(input int av, input int bv);
        return (av << (W - 1)) / bv;
    endfunction

    task automatic run_op(input logic sq, input int av, input int bv,
                          output int res_v, output int lat);
        @(negedge clk);
        start = 1'b1; op = sq; a = W'(av); b = W'(bv);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        res_v = int'(res);
        @(negedge clk);
        check(done == 1'b0, sq ? "R4 done width" : "R3 done width", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int rv;
        int lat;
        int held;
        int ndone;
        int first_lat;
        int first_res;

        // R6: reset state
        repeat (3) @(negedge clk);
        check(res == '0, "R6 result", int'(res), 0);
        check(done == 1'b0, "R6 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res == '0, "R6 result after release", int'(res), 0);

        // R1, R3: every divide pair
        for (int av = AMIN; av <= AMAX; av++) begin
            for (int bv = AMIN; bv <= AMAX; bv++) begin
                run_op(1'b0, av, bv, rv, lat);
                check(rv == exp_div(av, bv), "R1 quotient", rv, exp_div(av, bv));
                check(lat == NDIV, "R3 latency", lat, NDIV);
            end
        end

        // R2, R4, R8: every radicand, two divisor values on b_i
        for (int av = AMIN; av <= AMAX; av++) begin
            run_op(1'b1, av, AMIN, rv, lat);
            check(rv == isqrt(av << (W - 1)), "R2 root", rv, isqrt(av << (W - 1)));
            check(lat == NSQRT, "R4 latency", lat, NSQRT);
            run_op(1'b1, av, AMAX, rv, lat);
            check(rv == isqrt(av << (W - 1)), "R8 b ignored in root mode", rv, isqrt(av << (W - 1)));
        end

        // R9: boundaries
        run_op(1'b0, AMIN, AMIN, rv, lat);
        check(rv == AMIN, "R9 min/min", rv, AMIN);
        run_op(1'b0, AMAX, AMAX, rv, lat);
        check(rv == AMIN, "R9 max/max", rv, AMIN);
        run_op(1'b0, AMAX, AMIN, rv, lat);
        check(rv == AMAX, "R9 max/min", rv, AMAX);
        run_op(1'b0, AMIN, AMAX, rv, lat);
        check(rv == exp_div(AMIN, AMAX), "R9 min/max", rv, exp_div(AMIN, AMAX));

        // R5: start during busy is ignored
        @(negedge clk);
        start = 1'b1; op = 1'b0; a = W'(AMAX); b = W'(AMIN);
        lat = 0; ndone = 0; first_lat = -1; first_res = -1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (lat == 3) begin
                start = 1'b1; op = 1'b1; a = W'(AMIN); b = W'(AMAX);
            end
            if (done) begin
                ndone++;
                if (first_lat < 0) begin
                    first_lat = lat;
                    first_res = int'(res);
                end
            end
        end
        check(first_lat == NDIV, "R5 timing kept", first_lat, NDIV);
        check(first_res == AMAX, "R5 result kept", first_res, AMAX);
        check(ndone == 1, "R5 single done", ndone, 1);

        // R7: result holds without an accepted start
        held = int'(res);
        ndone = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            a = W'(AMIN + k); b = W'(AMAX - k); op = k[0];
            if (done) ndone++;
        end
        check(int'(res) == held, "R7 result held", int'(res), held);
        check(ndone == 0, "R7 no done", ndone, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule